// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block keeps the two error counters of a CAN node and turns them into the fault-confinement state that software reads. A protocol engine pulses one-cycle strobes for each finished frame: a transmit error, a receive error, a good transmit and a good receive. It also pulses a strobe with a three-bit last-error code whenever it sees a bus event. The block turns these into a status word and an error-counter word. It also raises an interrupt whenever the node enters or leaves the warning, passive or bus-off condition.

The host sees the status word, the error-counter word and an interrupt identification word. A host write to the status word clears the two success flags and loads the last-error field. Writing the "idle" code 7 is how the host learns whether any bus event happened since that write. A host read of the status word acknowledges the pending status-change interrupt. When the engine finishes its bus-off recovery, it pulses a recovery strobe. That strobe wipes both counters and leaves bus-off.

Top module: `can_fault_tracker`

## Requirements
- R1: After reset, statusWord, errCntWord and intIdWord read zero and irq is low.
- R2: While not bus-off, a transmit-error strobe adds 8 to the transmit counter (errCntWord bits 7:0) and a receive-error strobe adds 1 to the receive count. A success strobe in the same cycle subtracts 1 from the raised value.
- R3: A good-transmit or good-receive strobe subtracts 1 from its counter, and a counter at zero stays at zero.
- R4: The receive count saturates at 255. errCntWord bits 14:8 show the receive count, capped at 127, and bit 15 is set while the receive count exceeds 127.
- R5: statusWord bit 6 (warning) is set while either counter is 96 or more.
- R6: statusWord bit 5 (passive) is set while either counter exceeds 127.
- R7: A transmit error that would raise the transmit counter above 255 sets statusWord bit 7 (bus-off) and leaves the transmit counter at its old value.
- R8: While bus-off, all four frame strobes are ignored: neither counter changes and neither success flag is set.
- R9: A recovery strobe while bus-off clears bus-off and sets both counters to zero. Outside bus-off, the recovery strobe has no effect.
- R10: statusWord bit 4 (good receive) and bit 3 (good transmit) are set by their strobes and cleared by a host write. A strobe in the same cycle as the write wins.
- R11: statusWord bits 2:0 hold the last-error code (0 none, 1 stuff, 2 form, 3 ack, 4 bit1, 5 bit0, 6 CRC, 7 idle). The code loads from lecIn on lecStb, and from hostWrLec on a host write. The engine wins when both happen in the same cycle, and a written 7 is held until the next lecStb.
- R12: One cycle after any change of statusWord bits 7:5, in either direction, intIdWord bit 15 and irq go high. They stay high until a host read strobe. A new change in the same cycle as the read keeps them high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txErrStb | input | 1 | Transmit error seen on current frame |
| rxErrStb | input | 1 | Receive error seen on current frame |
| txOkStb | input | 1 | Frame transmitted without error |
| rxOkStb | input | 1 | Frame received without error |
| lecStb | input | 1 | Bus event; load lecIn into last-error field |
| lecIn | input | 3 | Last-error code from the protocol engine |
| recoverStb | input | 1 | Bus-off recovery finished |
| hostWrStb | input | 1 | Host write of the status word |
| hostWrLec | input | 3 | Last-error bits of the host write data |
| hostRdStb | input | 1 | Host read of the status word; acknowledges interrupt |
| statusWord | output | 16 | Bus-off, warning, passive, good rx, good tx, last-error code |
| errCntWord | output | 16 | Receive-passive flag, receive count, transmit count |
| intIdWord | output | 16 | Bit 15 set while a status change is pending |
| irq | output | 1 | Status-change interrupt line |

## Verification
A corrupted counter shows at errCntWord on the very next cycle, and it distorts the warning and passive bits in the same cycle. A stale state flag shows up one cycle later as a missing or spurious irq. Bus-off is the sticky state: a lost freeze or a wiped counter outside recovery keeps showing in errCntWord until the next recovery. The reference model steps once per cycle and is compared on every cycle, so any of these faults is reported in the cycle where it first appears.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;

  // Commands from control to datapath, already gated by bus-off.
  typedef struct packed {
    logic txUp;
    logic txDown;
    logic rxUp;
    logic rxDown;
    logic wipe;
  } cntCmd_t;

  typedef enum logic [2:0] {
    LEC_NONE  = 3'd0,
    LEC_STUFF = 3'd1,
    LEC_FORM  = 3'd2,
    LEC_ACK   = 3'd3,
    LEC_BIT1  = 3'd4,
    LEC_BIT0  = 3'd5,
    LEC_CRC   = 3'd6,
    LEC_IDLE  = 3'd7
  } lec_e;

endpackage

// File: rtl/fault_datapath.sv
module fault_datapath
  import can_fault_pkg::*;
#(
  parameter int TEC_W       = 8,
  parameter int REC_W       = 8,
  parameter int REC_FIELD_W = 7,
  parameter int TX_STEP     = 8,
  parameter int RX_STEP     = 1,
  parameter int WARN_AT     = 96,
  parameter int PASS_ABOVE  = 127
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cntCmd_t                cmd,
  output logic [TEC_W-1:0]       tecQ,
  output logic [REC_FIELD_W-1:0] recField,
  output logic                   recPassive,
  output logic                   warnLvl,
  output logic                   passLvl,
  output logic                   txOver
);

  localparam int TSW       = TEC_W + 2;
  localparam int RSW       = REC_W + 2;
  localparam int TEC_MAX   = (1 << TEC_W) - 1;
  localparam int REC_MAX   = (1 << REC_W) - 1;
  localparam int FIELD_MAX = (1 << REC_FIELD_W) - 1;

  logic [REC_W-1:0] recQ;
  logic [TSW-1:0]   tecRaised, tecNext;
  logic [RSW-1:0]   recRaised, recNext;
  logic             rxOver;

  // Transmit counter: step up on error, one down on success.
  always_comb begin
    tecRaised = TSW'(tecQ) + (cmd.txUp ? TSW'(TX_STEP) : '0);
    tecNext   = (cmd.txDown && tecRaised != '0) ? tecRaised - TSW'(1) : tecRaised;
    txOver    = tecNext > TSW'(TEC_MAX);
  end

  // Receive counter: same rule, saturating at the top.
  always_comb begin
    recRaised = RSW'(recQ) + (cmd.rxUp ? RSW'(RX_STEP) : '0);
    recNext   = (cmd.rxDown && recRaised != '0) ? recRaised - RSW'(1) : recRaised;
    rxOver    = recNext > RSW'(REC_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tecQ <= '0;
    end else if (cmd.wipe) begin
      tecQ <= '0;
    end else if (!txOver) begin
      tecQ <= tecNext[TEC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recQ <= '0;
    end else if (cmd.wipe) begin
      recQ <= '0;
    end else if (rxOver) begin
      recQ <= '1;
    end else begin
      recQ <= recNext[REC_W-1:0];
    end
  end

  // Level decode of the counters.
  always_comb begin
    recPassive = 32'(recQ) > PASS_ABOVE;
    warnLvl    = (32'(tecQ) >= WARN_AT) || (32'(recQ) >= WARN_AT);
    passLvl    = recPassive || (32'(tecQ) > PASS_ABOVE);
    recField   = (32'(recQ) > FIELD_MAX) ? '1 : recQ[REC_FIELD_W-1:0];
  end

endmodule

// File: rtl/fault_control.sv
module fault_control
  import can_fault_pkg::*;
#(
  parameter int LEC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txErrStb,
  input  logic             rxErrStb,
  input  logic             txOkStb,
  input  logic             rxOkStb,
  input  logic             lecStb,
  input  logic [LEC_W-1:0] lecIn,
  input  logic             recoverStb,
  input  logic             hostWrStb,
  input  logic [LEC_W-1:0] hostWrLec,
  input  logic             hostRdStb,
  input  logic             txOver,
  input  logic             warnLvl,
  input  logic             passLvl,
  output cntCmd_t          cmd,
  output logic             busOffQ,
  output logic             txOkQ,
  output logic             rxOkQ,
  output logic [LEC_W-1:0] lecQ,
  output logic             chgPendQ
);

  logic       live;
  logic [2:0] flagsNow, flagsPrev;

  assign live = !busOffQ;

  always_comb begin
    cmd        = '0;
    cmd.txUp   = live && txErrStb;
    cmd.txDown = live && txOkStb;
    cmd.rxUp   = live && rxErrStb;
    cmd.rxDown = live && rxOkStb;
    cmd.wipe   = busOffQ && recoverStb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busOffQ <= 1'b0;
    end else if (cmd.wipe) begin
      busOffQ <= 1'b0;
    end else if (txOver) begin
      busOffQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txOkQ <= 1'b0;
      rxOkQ <= 1'b0;
    end else begin
      if (live && txOkStb)  txOkQ <= 1'b1;
      else if (hostWrStb)   txOkQ <= 1'b0;
      if (live && rxOkStb)  rxOkQ <= 1'b1;
      else if (hostWrStb)   rxOkQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lecQ <= LEC_W'(LEC_NONE);
    end else if (lecStb) begin
      lecQ <= lecIn;
    end else if (hostWrStb) begin
      lecQ <= hostWrLec;
    end
  end

  // Status-change detection on the three state flags.
  assign flagsNow = {busOffQ, warnLvl, passLvl};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsPrev <= '0;
      chgPendQ  <= 1'b0;
    end else begin
      flagsPrev <= flagsNow;
      if (flagsNow != flagsPrev) chgPendQ <= 1'b1;
      else if (hostRdStb)        chgPendQ <= 1'b0;
    end
  end

endmodule

// File: rtl/can_fault_tracker.sv
module can_fault_tracker
  import can_fault_pkg::*;
#(
  parameter int TEC_W       = 8,
  parameter int REC_W       = 8,
  parameter int REC_FIELD_W = 7,
  parameter int TX_STEP     = 8,
  parameter int RX_STEP     = 1,
  parameter int WARN_AT     = 96,
  parameter int PASS_ABOVE  = 127,
  parameter int LEC_W       = 3,
  parameter int WORD_W      = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           txErrStb,
  input  logic                           rxErrStb,
  input  logic                           txOkStb,
  input  logic                           rxOkStb,
  input  logic                           lecStb,
  input  logic [LEC_W-1:0]               lecIn,
  input  logic                           recoverStb,
  input  logic                           hostWrStb,
  input  logic [LEC_W-1:0]               hostWrLec,
  input  logic                           hostRdStb,
  output logic [WORD_W-1:0]              statusWord,
  output logic [TEC_W+REC_FIELD_W:0]     errCntWord,
  output logic [WORD_W-1:0]              intIdWord,
  output logic                           irq
);

  localparam int STAT_USED = LEC_W + 5;

  cntCmd_t                cmd;
  logic [TEC_W-1:0]       tecQ;
  logic [REC_FIELD_W-1:0] recField;
  logic                   recPassive, warnLvl, passLvl, txOver;
  logic                   busOffQ, txOkQ, rxOkQ, chgPendQ;
  logic [LEC_W-1:0]       lecQ;

  fault_control #(.LEC_W(LEC_W)) i_control (
    .clk(clk), .rstN(rstN),
    .txErrStb(txErrStb), .rxErrStb(rxErrStb),
    .txOkStb(txOkStb), .rxOkStb(rxOkStb),
    .lecStb(lecStb), .lecIn(lecIn),
    .recoverStb(recoverStb),
    .hostWrStb(hostWrStb), .hostWrLec(hostWrLec),
    .hostRdStb(hostRdStb),
    .txOver(txOver), .warnLvl(warnLvl), .passLvl(passLvl),
    .cmd(cmd), .busOffQ(busOffQ), .txOkQ(txOkQ), .rxOkQ(rxOkQ),
    .lecQ(lecQ), .chgPendQ(chgPendQ)
  );

  fault_datapath #(
    .TEC_W(TEC_W), .REC_W(REC_W), .REC_FIELD_W(REC_FIELD_W),
    .TX_STEP(TX_STEP), .RX_STEP(RX_STEP),
    .WARN_AT(WARN_AT), .PASS_ABOVE(PASS_ABOVE)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .tecQ(tecQ), .recField(recField), .recPassive(recPassive),
    .warnLvl(warnLvl), .passLvl(passLvl), .txOver(txOver)
  );

  // Bus-off must stay the top bit of the status byte: the flags sit
  // just above the two success bits and the last-error field.
  assign statusWord = {{(WORD_W-STAT_USED){1'b0}},
                       busOffQ, warnLvl, passLvl, rxOkQ, txOkQ, lecQ};
  assign errCntWord = {recPassive, recField, tecQ};
  assign intIdWord  = {chgPendQ, {(WORD_W-1){1'b0}}};
  assign irq        = chgPendQ;

endmodule

// File: rtl/can_fault_tracker_chk.sv
module can_fault_tracker_chk #(
  parameter int TEC_W       = 8,
  parameter int REC_FIELD_W = 7,
  parameter int TX_STEP     = 8,
  parameter int LEC_W       = 3,
  parameter int WORD_W      = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       txErrStb,
  input logic                       txOkStb,
  input logic                       rxOkStb,
  input logic                       lecStb,
  input logic                       recoverStb,
  input logic                       hostWrStb,
  input logic                       hostRdStb,
  input logic [WORD_W-1:0]          statusWord,
  input logic [TEC_W+REC_FIELD_W:0] errCntWord,
  input logic                       irq
);

  localparam int BO  = LEC_W + 4;
  localparam int WN  = LEC_W + 3;
  localparam int PS  = LEC_W + 2;
  localparam int TOP = TEC_W + REC_FIELD_W;
  localparam int STEP_ROOM = (1 << TEC_W) - 1 - TX_STEP;

  // R2: a lone transmit error with room raises the count by the step
  a_r2_tx_step: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWord[BO] && txErrStb && !txOkStb && 32'(errCntWord[TEC_W-1:0]) <= STEP_ROOM)
    |=> errCntWord[TEC_W-1:0] == $past(errCntWord[TEC_W-1:0]) + TEC_W'(TX_STEP));

  // R6: receive-passive flag implies passive state
  a_r6_rx_passive: assert property (@(posedge clk) disable iff (!rstN)
    errCntWord[TOP] |-> statusWord[PS]);

  // R8: counters frozen while bus-off
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[BO] && !recoverStb && !hostWrStb)
    |=> ($stable(errCntWord) && $stable(statusWord[LEC_W+1:LEC_W])));

  // R9: recovery wipes the counters and leaves bus-off
  a_r9_recover: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[BO] && recoverStb) |=> (errCntWord == '0 && !statusWord[BO]));

  // R10: host write without strobes clears both success flags
  a_r10_ok_clear: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrStb && !txOkStb && !rxOkStb) |=> statusWord[LEC_W+1:LEC_W] == 2'b00);

  // R11: last-error field only moves on an event or a host write
  a_r11_lec_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!lecStb && !hostWrStb) |=> $stable(statusWord[LEC_W-1:0]));

  // R12: a change of any state flag raises the interrupt
  a_r12_change_irq: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[BO:PS] != $past(statusWord[BO:PS])) |=> irq);

  // R12: interrupt holds until a read
  a_r12_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !hostRdStb) |=> irq);

  // R5: warning accompanies bus-off entry from a full counter
  a_r5_warn_with_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[BO]) |-> statusWord[WN]);

endmodule

bind can_fault_tracker can_fault_tracker_chk #(
  .TEC_W(TEC_W), .REC_FIELD_W(REC_FIELD_W), .TX_STEP(TX_STEP),
  .LEC_W(LEC_W), .WORD_W(WORD_W)
) i_chk (
  .clk(clk), .rstN(rstN), .txErrStb(txErrStb), .txOkStb(txOkStb),
  .rxOkStb(rxOkStb), .lecStb(lecStb), .recoverStb(recoverStb),
  .hostWrStb(hostWrStb), .hostRdStb(hostRdStb),
  .statusWord(statusWord), .errCntWord(errCntWord), .irq(irq)
);

// File: tb/test_can_fault_tracker.sv
module test_can_fault_tracker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txErrStb = 0, rxErrStb = 0, txOkStb = 0, rxOkStb = 0;
  logic        lecStb = 0, recoverStb = 0, hostWrStb = 0, hostRdStb = 0;
  logic [2:0]  lecIn = 0, hostWrLec = 0;
  logic [15:0] statusWord, errCntWord, intIdWord;
  logic        irq;

  always #10 clk = ~clk;

  can_fault_tracker i_can_fault_tracker (
    .clk(clk), .rstN(rstN),
    .txErrStb(txErrStb), .rxErrStb(rxErrStb),
    .txOkStb(txOkStb), .rxOkStb(rxOkStb),
    .lecStb(lecStb), .lecIn(lecIn), .recoverStb(recoverStb),
    .hostWrStb(hostWrStb), .hostWrLec(hostWrLec), .hostRdStb(hostRdStb),
    .statusWord(statusWord), .errCntWord(errCntWord),
    .intIdWord(intIdWord), .irq(irq)
  );

  typedef struct {
    string       tag;
    logic [15:0] st;
    logic [15:0] ec;
    logic        pend;
    int          due;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   nApplied = 0;
  int   nBad = 0;
  bit   finished = 0;

  // Reference model state
  int       mTec = 0, mRec = 0;
  bit       mBo = 0, mTxOk = 0, mRxOk = 0, mPend = 0;
  bit [2:0] mLec = 0, mPrev = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit warnOf(int t, int r);
    return (t >= 96) || (r >= 96);
  endfunction

  function automatic bit passOf(int t, int r);
    return (t > 127) || (r > 127);
  endfunction

  task automatic apply(input string tag, input bit te, input bit re,
                       input bit to, input bit ro, input bit ls,
                       input bit [2:0] lv, input bit rcv, input bit wr,
                       input bit [2:0] wl, input bit rd);
    exp_t     e;
    bit [2:0] oldFl;
    bit       oldBo;
    int       b;
    @(negedge clk);
    txErrStb = te; rxErrStb = re; txOkStb = to; rxOkStb = ro;
    lecStb = ls; lecIn = lv; recoverStb = rcv;
    hostWrStb = wr; hostWrLec = wl; hostRdStb = rd;
    oldBo = mBo;
    oldFl = {mBo, warnOf(mTec, mRec), passOf(mTec, mRec)};
    if (oldFl != mPrev) mPend = 1; else if (rd) mPend = 0;
    mPrev = oldFl;
    if (oldBo) begin
      if (rcv) begin mTec = 0; mRec = 0; mBo = 0; end
    end else begin
      b = mTec + (te ? 8 : 0);
      if (to && b > 0) b--;
      if (b > 255) mBo = 1; else mTec = b;
      b = mRec + (re ? 1 : 0);
      if (ro && b > 0) b--;
      if (b > 255) b = 255;
      mRec = b;
    end
    if (!oldBo && to) mTxOk = 1; else if (wr) mTxOk = 0;
    if (!oldBo && ro) mRxOk = 1; else if (wr) mRxOk = 0;
    if (ls) mLec = lv; else if (wr) mLec = wl;
    e.tag  = tag;
    e.st   = {8'h00, mBo, warnOf(mTec, mRec), passOf(mTec, mRec), mRxOk, mTxOk, mLec};
    e.ec   = {(mRec > 127), (mRec > 127) ? 7'h7f : 7'(mRec), 8'(mTec)};
    e.pend = mPend;
    e.due  = cyc + 1;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    apply(tag, 0, 0, 0, 0, 0, 3'd0, 0, 0, 3'd0, 0);
  endtask

  // Monitor: pop and compare as results appear
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        nApplied++;
        if (statusWord !== e.st || errCntWord !== e.ec ||
            irq !== e.pend || intIdWord !== {e.pend, 15'h0}) begin
          nBad++;
          $display("FAIL %s: status=%h err=%h irq=%b intId=%h expected status=%h err=%h irq=%b",
                   e.tag, statusWord, errCntWord, irq, intIdWord, e.st, e.ec, e.pend);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nApplied, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    idle("R1");
    // R2 error increments
    apply("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    apply("R2", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    apply("R2", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    apply("R2", 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    // R3 decrements with floor at zero
    for (int i = 0; i < 24; i++) apply("R3", 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    // R10 success flags
    apply("R10", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    apply("R10", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    apply("R10", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    apply("R10", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    apply("R10", 0, 0, 1, 0, 0, 0, 0, 1, 0, 0);
    // R11 last-error code
    apply("R11", 0, 0, 0, 0, 1, 3'd3, 0, 0, 0, 0);
    apply("R11", 0, 0, 0, 0, 0, 0, 0, 1, 3'd7, 0);
    idle("R11");
    idle("R11");
    apply("R11", 0, 0, 0, 0, 1, 3'd6, 0, 0, 0, 0);
    apply("R11", 0, 0, 0, 0, 1, 3'd2, 0, 1, 3'd7, 0);
    // R5 warning entry, R12 interrupt
    for (int i = 0; i < 96; i++) apply("R5", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle("R12");
    idle("R12");
    apply("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    apply("R5", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    idle("R12");
    apply("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R6 passive, R4 field cap and saturation
    for (int i = 0; i < 40; i++) apply("R6", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 130; i++) apply("R4", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    apply("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 256; i++) apply("R4", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    apply("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R7 bus-off entry
    for (int i = 0; i < 32; i++) apply("R7", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle("R7");
    // R8 strobes ignored while bus-off
    apply("R8", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    apply("R8", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    apply("R8", 0, 0, 1, 1, 0, 0, 0, 0, 0, 1);
    apply("R8", 1, 1, 1, 1, 0, 0, 0, 0, 0, 0);
    // R9 recovery
    apply("R9", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    idle("R9");
    apply("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    apply("R9", 1, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    idle("R9");
    idle("R9");
    repeat (3) @(negedge clk);
    finished = 1;
    if (q.size() != 0) begin
      nBad++;
      $display("FAIL R1: %0d results never observed, expected 0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nBad);
    $finish;
  end

endmodule